// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block is the free-running bus time base of a serial bus link layer. A 24.576 MHz tick enable, given as a single-cycle pulse in the system clock domain, drives a 32-bit register. The register holds three cascaded fields. The sub-cycle offset sits in bits [11:0] and runs 0 to 3071. The cycle count sits in bits [24:12] and runs 0 to 7999. The seconds count sits in bits [31:25] and runs 0 to 127. Each field wraps at its true modulus and not at a power of two, so 3072 ticks make one bus cycle and 8000 cycles make one second.

The packed register is presented on an output at all times. Two single-cycle strobes come with it. One marks the start of every new bus cycle. The other flags a 64-second event whenever the top seconds bit changes state.

A load port lets software or a bus master overwrite the whole register in one clock. The load is a plain qualifier with no ready signal. It is always accepted, it cannot be held off, and there is no back-pressure anywhere on the block.

Top module: `cycle_timer_top`

## Requirements
- R1: After reset the timer value is zero and both strobes are low.
- R2: Each cycle with tick_en high and load_en low adds one to the offset field (bits [11:0]). The step after offset 3071, or after any value above it, gives 0.
- R3: The cycle count field (bits [24:12]) adds one in the clock where the offset wraps. The step after count 7999, or after any value above it, gives 0.
- R4: The seconds field (bits [31:25]) adds one in the clock where the count wraps. It steps from 127 to 0 without saturating.
- R5: All carries land in the same clock, so a full rollover from 0xFFF3FBFF goes straight to 0x00000000 on a single tick.
- R6: With load_en high, timer_value equals load_value from the next cycle on, whether or not tick_en is high in that cycle.
- R7: cycle_start is high for exactly one cycle, in the first cycle that shows the wrapped offset of 0, and only after a tick-driven offset wrap. A load never raises it.
- R8: sec64_event is high for exactly one cycle, in the first cycle that shows a changed bit 31, whether the change came from a tick or from a load.
- R9: With tick_en and load_en both low, the timer value holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 24.576 MHz tick qualifier |
| load_en | input | 1 | Write the whole register this cycle |
| load_value | input | 32 | Value written on load |
| timer_value | output | 32 | Packed register {seconds, count, offset} |
| cycle_start | output | 1 | One-cycle new-cycle strobe |
| sec64_event | output | 1 | One-cycle strobe on a change of bit 31 |

## Verification
The assertions assume that every loaded value has its offset no higher than 3071 and its count no higher than 7999. Under that assumption, an offset of zero after a tick-driven wrap always means a real cycle start. The assertions also assume that tick_en and load_en are sampled as clean single-cycle levels. All the stimulus loads in-range values only, and it drives inputs on the falling edge. Long tick runs cover the offset-to-count carry. Loads placed just below each rollover point reach the count-to-seconds carry and the top-bit toggle, which ticks alone could not reach in a short run.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int OFFSET_W   = 12;
  localparam int COUNT_W    = 13;
  localparam int SEC_W      = 7;
  localparam int OFFSET_MOD = 3072;
  localparam int COUNT_MOD  = 8000;
  localparam int SEC_MOD    = 128;
  localparam int TIMER_W    = OFFSET_W + COUNT_W + SEC_W;

  typedef struct packed {
    logic [SEC_W-1:0]    sec;
    logic [COUNT_W-1:0]  count;
    logic [OFFSET_W-1:0] offset;
  } timer_t;
endpackage

// File: rtl/cyc_field_counter.sv
module cyc_field_counter #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  // carry out is combinational so the whole cascade settles in one clock
  assign wrap = inc && (value >= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        value <= '0;
    else if (load_en)  value <= load_val;
    else if (inc)      value <= wrap ? '0 : value + W'(1);
  end
endmodule

// File: rtl/cyc_strobe_gen.sv
module cyc_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic offset_wrap,
  input  logic top_bit,
  output logic cycle_start,
  output logic sec64_event
);
  logic wrap_q;
  logic top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrap_q <= 1'b0;
      top_q  <= 1'b0;
    end else begin
      wrap_q <= offset_wrap;
      top_q  <= top_bit;
    end
  end

  assign cycle_start = wrap_q;
  assign sec64_event = top_bit ^ top_q;
endmodule

// File: rtl/cycle_timer_top.sv
module cycle_timer_top
  import cyc_timer_pkg::*;
#(
  parameter int OFS_W   = OFFSET_W,
  parameter int CNT_W   = COUNT_W,
  parameter int SECS_W  = SEC_W,
  parameter int OFS_MOD = OFFSET_MOD,
  parameter int CNT_MOD = COUNT_MOD,
  localparam int TW     = OFS_W + CNT_W + SECS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load_en,
  input  logic [TW-1:0] load_value,
  output logic [TW-1:0] timer_value,
  output logic          cycle_start,
  output logic          sec64_event
);
  localparam int CNT_LSB = OFS_W;
  localparam int SEC_LSB = OFS_W + CNT_W;

  logic [OFS_W-1:0]  ofs_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SECS_W-1:0] sec_q;
  logic ofs_inc, ofs_wrap, cnt_wrap, sec_wrap;

  assign ofs_inc = tick_en && !load_en;

  cyc_field_counter #(.W(OFS_W), .MOD(OFS_MOD)) u_ofs (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .load_val(load_value[CNT_LSB-1:0]), .inc(ofs_inc),
    .value(ofs_q), .wrap(ofs_wrap)
  );

  cyc_field_counter #(.W(CNT_W), .MOD(CNT_MOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .load_val(load_value[SEC_LSB-1:CNT_LSB]), .inc(ofs_wrap),
    .value(cnt_q), .wrap(cnt_wrap)
  );

  cyc_field_counter #(.W(SECS_W), .MOD(1 << SECS_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .load_val(load_value[TW-1:SEC_LSB]), .inc(cnt_wrap),
    .value(sec_q), .wrap(sec_wrap)
  );

  assign timer_value = {sec_q, cnt_q, ofs_q};

  cyc_strobe_gen u_strb (
    .clk(clk), .rst_n(rst_n), .offset_wrap(ofs_wrap),
    .top_bit(sec_q[SECS_W-1]),
    .cycle_start(cycle_start), .sec64_event(sec64_event)
  );

  logic unused_wrap;
  assign unused_wrap = sec_wrap;
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        load_en,
  input logic [31:0] load_value,
  input logic [31:0] timer_value,
  input logic        cycle_start,
  input logic        sec64_event
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (timer_value == 32'h0));

  // R2
  offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_en && timer_value[11:0] < 12'd3071)
    |=> (timer_value[11:0] == $past(timer_value[11:0]) + 12'd1)
        && (timer_value[31:12] == $past(timer_value[31:12])));

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> timer_value == $past(load_value));

  // R7
  cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (timer_value[11:0] == 12'd0) && $past(tick_en) && !$past(load_en));

  // R7
  cycle_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);

  // R8
  sec64_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec64_event |-> timer_value[31] != $past(timer_value[31]));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_en) |=> $stable(timer_value));
endmodule

bind cycle_timer_top cycle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
  .load_value(load_value), .timer_value(timer_value),
  .cycle_start(cycle_start), .sec64_event(sec64_event)
);

// File: tb/cycle_timer_top_test.sv
module cycle_timer_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_value = 32'h0;
  logic [31:0] timer_value;
  logic        cycle_start, sec64_event;
  int errors = 0;
  int checks = 0;
  int pulses;

  always #4 clk = ~clk;

  cycle_timer_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
    .load_value(load_value), .timer_value(timer_value),
    .cycle_start(cycle_start), .sec64_event(sec64_event)
  );

  // {load, ticks, expected}
  localparam logic [95:0] VEC [6] = '{
    {32'h00000BFE, 32'd2, 32'h00001000},  // R2 R3 offset carry
    {32'h0BF3FBFF, 32'd1, 32'h0C000000},  // R4 count carry into seconds
    {32'hFFF3FBFF, 32'd1, 32'h00000000},  // R5 full rollover
    {32'h00000000, 32'd5, 32'h00000005},  // R2 plain steps
    {32'h00000BFF, 32'd3, 32'h00001002},  // R3 wrap then continue
    {32'h7FF3FBFF, 32'd1, 32'h80000000}   // R4 seconds 63 to 64
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] v);
    load_en = 1'b1; load_value = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_ticks(int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 value", timer_value, 32'h0);
    check("R1 strobes", {30'h0, cycle_start, sec64_event}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      do_load(VEC[k][95:64]);
      do_ticks(int'(VEC[k][63:32]));
      check("R2-chain vector", timer_value, VEC[k][31:0]);
    end

    // R7 strobe timing
    do_load(32'h00000BFE);
    check("R7 no strobe on load", {31'h0, cycle_start}, 32'h0);
    do_ticks(1);
    check("R7 before wrap", {31'h0, cycle_start}, 32'h0);
    do_ticks(1);
    check("R7 at wrap", {31'h0, cycle_start}, 32'h1);
    check("R3 at wrap", timer_value, 32'h00001000);
    @(negedge clk);
    check("R7 one cycle", {31'h0, cycle_start}, 32'h0);

    // R8 on tick
    do_load(32'h0);
    do_load(32'h7FF3FBFF);
    check("R8 no event", {31'h0, sec64_event}, 32'h0);
    do_ticks(1);
    check("R8 event on tick", {31'h0, sec64_event}, 32'h1);
    @(negedge clk);
    check("R8 one cycle", {31'h0, sec64_event}, 32'h0);
    // R8 on load
    do_load(32'h0);
    check("R8 event on load", {31'h0, sec64_event}, 32'h1);

    // R6 priority over tick
    tick_en = 1'b1;
    do_load(32'h00000123);
    tick_en = 1'b0;
    check("R6 load priority", timer_value, 32'h00000123);

    // R9 hold
    repeat (5) @(negedge clk);
    check("R9 hold", timer_value, 32'h00000123);

    // R3 long run, count pulses
    do_load(32'h0);
    pulses = 0;
    tick_en = 1'b1;
    for (int i = 0; i < 3072 * 2 + 7; i++) begin
      @(negedge clk);
      if (cycle_start) pulses++;
    end
    tick_en = 1'b0;
    check("R3 long run", timer_value, 32'h00002007);
    check("R7 pulse count", pulses, 32'd2);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset again", timer_value, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule